// File: doc/BRIEF.md
# Buffered Manchester Serial Encoder

This block sends host bytes one bit at a time on a single output pin, coded in Manchester form. The host writes a byte with a one-cycle strobe. The byte goes into a holding register. As soon as the shift stage is free, the byte moves into it. The host can therefore queue the next byte while the current one is still on the line. An external clock-enable tick marks each half-bit slot, so the tick rate sets the line rate.

Each byte goes out as a frame:
- The frame opens with a four-slot marker.
- The data follows, most significant bit first.
- A four-slot closing marker ends the frame.

Both markers hold one level for a whole bit time, which a valid data bit never does. A receiver can use this to find frame edges.

Two status outputs tell the host what to do next:
- `buf_empty` means the holding register can take another byte.
- `enc_done` means nothing is queued and nothing is being sent.

Clearing `enable` stops the block at once.

Top module: `manch_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tx_out` is 0, `buf_empty` is 1 and `enc_done` is 1.
- R2: A frame is 24 half-bit slots, sent in this order:
  - the start marker 1,1,0,0;
  - eight data bits, most significant first, where a 1 is sent as 1,0 and a 0 as 0,1;
  - the end marker 0,0,1,1.
  
  Each slot begins at a clock edge where `tick` is 1 and lasts until the next such edge. At the tick after the last slot, `tx_out` returns to 0, which is also its idle level.
- R3: A strobe while `enable` is 1 stores `wr_data` and drives `buf_empty` to 0 in the next cycle. If no frame is being sent, the byte moves to the shift stage one cycle later and `buf_empty` returns to 1.
- R4: A byte written while a frame is being sent goes out directly after that frame, with exactly one idle slot (`tx_out` 0) between the two frames.
- R5: A second write while the holding register is still full replaces the pending byte. Only the last byte written is sent.
- R6: A strobe while `enable` is 1 drives `enc_done` to 0 in the next cycle.
- R7: `enc_done` returns to 1 at the tick that ends a frame, but only if the holding register is empty then. It stays 0 between two queued frames, and it is never 1 while a frame is being sent.
- R8: While `enable` is 0, strobes are ignored, `enc_done` is 1 and `tx_out` stays 0. A byte strobed while disabled is never sent.
- R9: When `enable` is cleared, the next cycle shows `tx_out` 0, `buf_empty` 1 and `enc_done` 1. Both the frame in progress and any pending byte are discarded.
- R10: While `enable` is 1, `tx_out` changes only at clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Encoder enable; clearing it aborts all activity |
| tick | input | 1 | Half-bit slot clock enable |
| wr_stb | input | 1 | One-cycle write strobe for the data register |
| wr_data | input | 8 | Byte to encode |
| tx_out | output | 1 | Manchester serial output, idle low |
| buf_empty | output | 1 | Holding register can accept a byte |
| enc_done | output | 1 | No byte pending and no frame on the line |

## Verification
All 256 byte values are sent and compared slot by slot against frames built arithmetically in the bench. A swapped half-bit polarity, a reversed bit order or a wrong marker therefore shows up as a mismatched capture.

The bench also covers these cases:
- **Back-to-back queueing.** A design that loads the shift stage too early, or drops the idle gap, would corrupt the second frame.
- **A pending byte overwritten before it is loaded.** A design that kept the first byte would send the wrong frame.
- **Completion between queued frames.** A design that raised `enc_done` between the two frames would let the wait end early.
- **Strobes while disabled.** A design that latched the byte would send it after re-enable.
- **Disabling mid-frame with a byte pending.** A design that only paused, rather than flushing, would resume sending.

// File: rtl/manch_pkg.sv
package manch_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned MARK_W  = 4;
    localparam logic [MARK_W-1:0] HEAD_MARK = 4'b1100;
    localparam logic [MARK_W-1:0] TAIL_MARK = 4'b0011;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_SEND = 1'b1
    } sh_state_e;

    typedef struct packed {
        logic                 full;
        logic [BYTE_W-1:0]    data;
    } hold_t;

    // Manchester half-bit pair, first half in the upper bit
    function automatic logic [1:0] code_pair(input logic b);
        return b ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/manch_hold.sv
module manch_hold
    import manch_pkg::*;
#(
    parameter int unsigned DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    logic          full_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (wr_stb) begin
            data_q <= wr_data;
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign full = full_q;
    assign data = data_q;

    // R3
    hold_fill_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> $past(wr_stb && enable));

    // R9
    hold_flush_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !full_q);

endmodule

// File: rtl/manch_shift.sv
module manch_shift
    import manch_pkg::*;
#(
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned MW = MARK_W,
    parameter logic [MW-1:0] HEAD = HEAD_MARK,
    parameter logic [MW-1:0] TAIL = TAIL_MARK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          busy,
    output logic          fin,
    output logic          tx
);

    localparam int unsigned FRAME_W = 2 * DW + 2 * MW;
    localparam int unsigned CW      = $clog2(FRAME_W + 1);

    sh_state_e            st_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [CW-1:0]        rem_q;
    logic                 tx_q;
    logic [2*DW-1:0]      coded;
    logic [FRAME_W-1:0]   built;

    for (genvar g = 0; g < DW; g++) begin : g_code
        assign coded[2*g+1:2*g] = code_pair(load_data[g]);
    end

    assign built = {HEAD, coded, TAIL};
    assign busy  = (st_q == SH_SEND);
    assign fin   = busy && tick && !abort && (rem_q == '0);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st_q    <= SH_IDLE;
            frame_q <= '0;
            rem_q   <= '0;
            tx_q    <= 1'b0;
        end else begin
            case (st_q)
                SH_IDLE: begin
                    if (load) begin
                        st_q    <= SH_SEND;
                        frame_q <= built;
                        rem_q   <= CW'(FRAME_W);
                    end
                end
                SH_SEND: begin
                    if (tick) begin
                        if (rem_q != '0) begin
                            tx_q    <= frame_q[FRAME_W-1];
                            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                            rem_q   <= rem_q - CW'(1);
                        end else begin
                            tx_q <= 1'b0;
                            st_q <= SH_IDLE;
                        end
                    end
                end
                default: st_q <= SH_IDLE;
            endcase
        end
    end

    assign tx = tx_q;

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_q);

    // R10
    slot_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick) && !$past(abort)) |-> $stable(tx_q));

    // R2
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx_q);

endmodule

// File: rtl/manch_flag.sv
module manch_flag (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic wr_stb,
    input  logic fin,
    input  logic pending,
    output logic done
);

    logic done_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            done_q <= 1'b1;
        end else if (wr_stb) begin
            done_q <= 1'b0;
        end else if (fin && !pending) begin
            done_q <= 1'b1;
        end
    end

    assign done = done_q;

    // R6
    wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && enable) |=> !done_q);

    // R8
    off_done_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> done_q);

endmodule

// File: rtl/manch_tx.sv
module manch_tx
    import manch_pkg::*;
#(
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned MW = MARK_W,
    parameter logic [MW-1:0] HEAD = HEAD_MARK,
    parameter logic [MW-1:0] TAIL = TAIL_MARK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          tick,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    output logic          tx_out,
    output logic          buf_empty,
    output logic          enc_done
);

    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          sh_busy;
    logic          sh_fin;
    logic          take;

    assign take = enable && hold_full && !sh_busy;

    manch_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    manch_shift #(.DW(DW), .MW(MW), .HEAD(HEAD), .TAIL(TAIL)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .abort     (!enable),
        .tick      (tick),
        .load      (take),
        .load_data (hold_data),
        .busy      (sh_busy),
        .fin       (sh_fin),
        .tx        (tx_out)
    );

    manch_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .wr_stb  (wr_stb),
        .fin     (sh_fin),
        .pending (hold_full),
        .done    (enc_done)
    );

    assign buf_empty = !hold_full;

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        enc_done |-> (!sh_busy && !hold_full));

endmodule

// File: tb/manch_tx_test.sv
module manch_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_out;
    logic       buf_empty;
    logic       enc_done;

    int total = 0;
    int bad = 0;
    int glitches = 0;
    int hi_seen = 0;
    int cycles = 0;
    logic [63:0] hist = '0;
    logic tick_e = 1'b0, en_e = 1'b0, rst_e = 1'b1, prev_tx = 1'b0;

    manch_tx uut (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick),
        .wr_stb(wr_stb), .wr_data(wr_data),
        .tx_out(tx_out), .buf_empty(buf_empty), .enc_done(enc_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick once every four clocks, driven away from the active edge
    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            tick = (phase == 3);
            phase = (phase + 1) % 4;
        end
    end

    always @(posedge clk) begin
        tick_e <= tick;
        en_e   <= enable;
        rst_e  <= rst;
        cycles <= cycles + 1;
    end

    always @(negedge clk) begin
        if (tick_e) hist <= {hist[62:0], tx_out};
        if (tx_out) hi_seen <= hi_seen + 1;
        if (tx_out !== prev_tx && !tick_e && en_e && !rst_e)
            glitches <= glitches + 1;
        prev_tx <= tx_out;
    end

    function automatic logic [23:0] exp_frame(input logic [7:0] b);
        logic [23:0] f;
        f = 24'h0;
        f = {f[19:0], 4'b1100};
        for (int i = 7; i >= 0; i--)
            f = {f[21:0], (b[i] ? 2'b10 : 2'b01)};
        f = {f[19:0], 4'b0011};
        return f;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic wait_done();
        while (!enc_done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_empty();
        while (!buf_empty) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tx_out == 0 && buf_empty == 1 && enc_done == 1, "R1",
            {61'b0, tx_out, buf_empty, enc_done}, 64'b011);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_out == 0 && buf_empty == 1 && enc_done == 1, "R1",
            {61'b0, tx_out, buf_empty, enc_done}, 64'b011);
        enable = 1'b1;
        repeat (2) @(negedge clk);

        // R3 / R6: first write from idle
        put(8'hA5);
        chk(buf_empty == 0, "R3", {63'b0, buf_empty}, 64'd0);
        chk(enc_done == 0, "R6", {63'b0, enc_done}, 64'd0);
        @(negedge clk);
        chk(buf_empty == 1, "R3", {63'b0, buf_empty}, 64'd1);
        wait_done();
        chk(hist[24:0] == {exp_frame(8'hA5), 1'b0}, "R2",
            {39'b0, hist[24:0]}, {39'b0, exp_frame(8'hA5), 1'b0});

        // R2: sweep every byte value
        for (int v = 0; v < 256; v++) begin
            put(v[7:0]);
            wait_done();
            chk(hist[24:0] == {exp_frame(v[7:0]), 1'b0}, "R2",
                {39'b0, hist[24:0]}, {39'b0, exp_frame(v[7:0]), 1'b0});
        end

        // R4 / R7: back-to-back queueing
        put(8'h3C);
        wait_empty();
        put(8'hC3);
        chk(buf_empty == 0 && enc_done == 0, "R7",
            {62'b0, buf_empty, enc_done}, 64'd0);
        wait_done();
        chk(hist[49:0] == {exp_frame(8'h3C), 1'b0, exp_frame(8'hC3), 1'b0}, "R4",
            {14'b0, hist[49:0]}, {14'b0, exp_frame(8'h3C), 1'b0, exp_frame(8'hC3), 1'b0});

        // R5: overwrite a pending byte
        put(8'h81);
        wait_empty();
        put(8'h11);
        put(8'hE7);
        wait_done();
        chk(hist[49:0] == {exp_frame(8'h81), 1'b0, exp_frame(8'hE7), 1'b0}, "R5",
            {14'b0, hist[49:0]}, {14'b0, exp_frame(8'h81), 1'b0, exp_frame(8'hE7), 1'b0});

        // R8: writes ignored while disabled
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        hi_seen = 0;
        put(8'hFF);
        chk(buf_empty == 1 && enc_done == 1, "R8",
            {62'b0, buf_empty, enc_done}, 64'b11);
        repeat (120) @(negedge clk);
        chk(hi_seen == 0, "R8", 64'(hi_seen), 64'd0);
        enable = 1'b1;
        @(negedge clk);
        chk(enc_done == 1 && buf_empty == 1, "R8",
            {62'b0, buf_empty, enc_done}, 64'b11);
        repeat (150) @(negedge clk);
        chk(hi_seen == 0, "R8", 64'(hi_seen), 64'd0);

        // R9: abort mid-frame with a byte pending
        put(8'hFF);
        repeat (30) @(negedge clk);
        put(8'h55);
        enable = 1'b0;
        @(negedge clk);
        chk(tx_out == 0 && buf_empty == 1 && enc_done == 1, "R9",
            {61'b0, tx_out, buf_empty, enc_done}, 64'b011);
        enable = 1'b1;
        @(negedge clk);
        hi_seen = 0;
        repeat (200) @(negedge clk);
        chk(hi_seen == 0, "R9", 64'(hi_seen), 64'd0);
        chk(enc_done == 1, "R9", {63'b0, enc_done}, 64'd1);

        // R10: no output change off a tick edge while enabled
        chk(glitches == 0, "R10", 64'(glitches), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(negedge clk) begin
        if (cycles > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule